// File: doc/BRIEF.md
# Two-Cycle Decode Sequencer with Register Range Check

This block is the control part of the decode stage of a small in-order core. Most instructions finish decode in one cycle. Three-source bit-manipulation instructions need two cycles, because the register file has only two read ports. In the first cycle, read port A carries rs1 and read port B carries rs2. In the second cycle, port A is switched to rs3. The block drives both read addresses and a first-cycle flag that the execute logic uses to pick its operands.

For a core built with 16 architectural registers, the block checks every register field the instruction uses. It raises an illegal-register exception request in the cycle the instruction is first presented. The check is taken from the instruction fields, not from the address currently on port A. An out-of-range rs3 is therefore caught before the second cycle begins. An instruction that has reached its second cycle never raises an exception. The two-state machine returns to the first-cycle state on a completion pulse or on a flush from a later stage, so the flag cannot go stale.

States: `ST_FIRST` (first cycle of any instruction) and `ST_MULTI` (second cycle of a three-source instruction). The transitions are:
- ENTER: `ST_FIRST` to `ST_MULTI`, taken on a valid, legal three-source instruction with no stall and no flush.
- DONE: `ST_MULTI` to `ST_FIRST`, taken on the completion pulse when the stage is not stalled.
- FLUSH: any state to `ST_FIRST`.
- HOLD: the state is kept in every other case.

Top module: `decode_sequencer`

## Requirements
- R1: After reset, `first_cycle_o` is 1 and no exception output is raised while `instr_valid_i` is 0.
- R2: In `ST_FIRST`, `rf_raddr_a_o` equals rs1 (bits 19:15) and `rf_raddr_b_o` equals rs2 (bits 24:20) of `instr_i`.
- R3: A three-source instruction is one with opcode bits 6:0 = 0110011 and bits 26:25 = 11. When it is valid and accepted with no stall, flush or exception, the next cycle is `ST_MULTI`. In that cycle `first_cycle_o` is 0, port A carries rs3 (bits 31:27) and port B still carries rs2.
- R4: With NUM_REGS = 16, `illegal_reg_o` and `exc_req_o` go high in the first cycle when a used field is 16 or more. The fields checked are:
  - rd (bits 11:7) and rs1, for opcodes 0110011 and 0010011;
  - rs2, for opcode 0110011 only (bits 24:20 of opcode 0010011 are an immediate and are not checked);
  - rs3, for three-source instructions only.
- R5: A three-source instruction with an out-of-range rs3 is flagged in its first cycle and does not enter `ST_MULTI`.
- R6: Any opcode other than 0110011 or 0010011 raises `illegal_instr_o` and `exc_req_o` without `illegal_reg_o`, and does not enter `ST_MULTI`.
- R7: In `ST_MULTI`, no exception output is raised, whatever `instr_i` holds.
- R8: In `ST_MULTI`, `mc_done_i` without stall returns the state to `ST_FIRST` on the next clock.
- R9: `stall_i` without flush holds the state in both states, including against a three-source instruction or `mc_done_i`.
- R10: `flush_i` forces `ST_FIRST` on the next clock, with priority over stall and completion, and blocks entry to `ST_MULTI`.
- R11: After an instruction that raised an exception, a following three-source instruction sees `first_cycle_o` = 1 with port A = its rs1, and then enters `ST_MULTI` normally.
- R12: With NUM_REGS = 32, no register field is ever flagged illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_valid_i | input | 1 | The instruction word is valid |
| instr_i | input | 32 | Instruction word held in decode |
| stall_i | input | 1 | Decode stage stalled |
| flush_i | input | 1 | Kill or exception from a later stage |
| mc_done_i | input | 1 | Second-cycle completion pulse |
| rf_raddr_a_o | output | 5 | Read port A address |
| rf_raddr_b_o | output | 5 | Read port B address |
| first_cycle_o | output | 1 | Instruction is in its first decode cycle |
| illegal_reg_o | output | 1 | Register index out of range |
| illegal_instr_o | output | 1 | Unknown opcode |
| exc_req_o | output | 1 | Exception request to the controller |

## Verification
Two pieces of logic can act in the same cycle: the register range check, and the acceptance of a three-source instruction into its second cycle. The bench provokes this with a three-source instruction whose rs3 is out of range. It also runs an illegal rd followed directly by a legal three-source instruction. The result is judged on the next cycle: `first_cycle_o` must still be 1 and port A must show the new rs1. A second overlap is flush against stall or completion in `ST_MULTI`. Here the state must read `ST_FIRST` one clock later.

// File: rtl/dseq_pkg.sv
package dseq_pkg;
    localparam int ILEN   = 32;
    localparam int RIDX_W = 5;
    localparam int OPC_W  = 7;

    localparam logic [OPC_W-1:0] OPC_REGREG = 7'b0110011;
    localparam logic [OPC_W-1:0] OPC_REGIMM = 7'b0010011;

    typedef enum logic [0:0] {
        ST_FIRST = 1'b0,
        ST_MULTI = 1'b1
    } dseq_state_e;

    typedef struct packed {
        logic [RIDX_W-1:0] rd;
        logic [RIDX_W-1:0] rs1;
        logic [RIDX_W-1:0] rs2;
        logic [RIDX_W-1:0] rs3;
        logic              is_regreg;
        logic              is_regimm;
        logic              is_ternary;
        logic              bad_opc;
    } dseq_fields_t;
endpackage

// File: rtl/dseq_decode.sv
module dseq_decode
    import dseq_pkg::*;
(
    input  logic [ILEN-1:0] instr_i,
    output dseq_fields_t    fields_o
);
    logic [OPC_W-1:0] opc;
    logic [2:0]       unused_funct3;

    assign opc           = instr_i[OPC_W-1:0];
    assign unused_funct3 = instr_i[14:12];

    always_comb begin
        fields_o.rd         = instr_i[11:7];
        fields_o.rs1        = instr_i[19:15];
        fields_o.rs2        = instr_i[24:20];
        fields_o.rs3        = instr_i[31:27];
        fields_o.is_regreg  = (opc == OPC_REGREG);
        fields_o.is_regimm  = (opc == OPC_REGIMM);
        fields_o.is_ternary = (opc == OPC_REGREG) && (instr_i[26:25] == 2'b11);
        fields_o.bad_opc    = !((opc == OPC_REGREG) || (opc == OPC_REGIMM));
    end
endmodule

// File: rtl/dseq_regcheck.sv
module dseq_regcheck
    import dseq_pkg::*;
#(
    parameter int NUM_REGS = 16
) (
    input  dseq_fields_t fields_i,
    output logic         over_o
);
    localparam int NUM_FIELDS = 4;
    localparam int FULL_REGS  = 1 << RIDX_W;

    generate
        if (NUM_REGS < FULL_REGS) begin : g_check
            localparam logic [RIDX_W:0] LIMIT = (RIDX_W+1)'(NUM_REGS);
            logic [RIDX_W-1:0]     idx  [NUM_FIELDS];
            logic [NUM_FIELDS-1:0] used;
            logic [NUM_FIELDS-1:0] over;
            logic                  unused_bad;

            assign unused_bad = fields_i.bad_opc;

            always_comb begin
                idx[0]  = fields_i.rd;
                idx[1]  = fields_i.rs1;
                idx[2]  = fields_i.rs2;
                idx[3]  = fields_i.rs3;
                used[0] = fields_i.is_regreg || fields_i.is_regimm;
                used[1] = fields_i.is_regreg || fields_i.is_regimm;
                used[2] = fields_i.is_regreg;
                used[3] = fields_i.is_ternary;
            end

            for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
                assign over[i] = used[i] && ({1'b0, idx[i]} >= LIMIT);
            end

            assign over_o = |over;
        end else begin : g_nocheck
            logic unused_fields;
            assign unused_fields = ^fields_i;
            assign over_o        = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/dseq_fsm.sv
module dseq_fsm
    import dseq_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        go_multi_i,
    input  logic        mc_done_i,
    input  logic        stall_i,
    input  logic        flush_i,
    output dseq_state_e state_o
);
    dseq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FIRST: if (!flush_i && !stall_i && go_multi_i) state_d = ST_MULTI;
            ST_MULTI: if (flush_i || (mc_done_i && !stall_i)) state_d = ST_FIRST;
            default:  state_d = ST_FIRST;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_FIRST;
        else         state_q <= state_d;
    end

    assign state_o = state_q;
endmodule

// File: rtl/decode_sequencer.sv
module decode_sequencer
    import dseq_pkg::*;
#(
    parameter int NUM_REGS = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              instr_valid_i,
    input  logic [ILEN-1:0]   instr_i,
    input  logic              stall_i,
    input  logic              flush_i,
    input  logic              mc_done_i,
    output logic [RIDX_W-1:0] rf_raddr_a_o,
    output logic [RIDX_W-1:0] rf_raddr_b_o,
    output logic              first_cycle_o,
    output logic              illegal_reg_o,
    output logic              illegal_instr_o,
    output logic              exc_req_o
);
    dseq_fields_t fields;
    dseq_state_e  state;
    logic         over;
    logic         go_multi;

    dseq_decode u_decode (
        .instr_i  (instr_i),
        .fields_o (fields)
    );

    dseq_regcheck #(.NUM_REGS(NUM_REGS)) u_regcheck (
        .fields_i (fields),
        .over_o   (over)
    );

    dseq_fsm u_fsm (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .go_multi_i (go_multi),
        .mc_done_i  (mc_done_i),
        .stall_i    (stall_i),
        .flush_i    (flush_i),
        .state_o    (state)
    );

    // Output process: all outputs derive from the state and the held fields.
    always_comb begin
        first_cycle_o   = 1'b0;
        illegal_reg_o   = 1'b0;
        illegal_instr_o = 1'b0;
        rf_raddr_a_o    = fields.rs1;
        rf_raddr_b_o    = fields.rs2;
        unique case (state)
            ST_FIRST: begin
                first_cycle_o   = 1'b1;
                illegal_reg_o   = instr_valid_i && over;
                illegal_instr_o = instr_valid_i && fields.bad_opc;
            end
            ST_MULTI: begin
                rf_raddr_a_o = fields.rs3;
            end
            default: ;
        endcase
        exc_req_o = illegal_reg_o || illegal_instr_o;
        go_multi  = instr_valid_i && fields.is_ternary && !exc_req_o;
    end
endmodule

// File: rtl/dseq_chk.sv
module dseq_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic instr_valid_i,
    input logic stall_i,
    input logic flush_i,
    input logic mc_done_i,
    input logic first_cycle_o,
    input logic exc_req_o
);
    AST_NO_EXC_IN_MULTI: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !first_cycle_o |-> !exc_req_o); // R7

    AST_FLUSH_TO_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_i |=> first_cycle_o); // R10

    AST_STALL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stall_i && !flush_i) |=> $stable(first_cycle_o)); // R9

    AST_EXC_BLOCKS_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (first_cycle_o && exc_req_o) |=> first_cycle_o); // R5

    AST_DONE_RETURNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!first_cycle_o && mc_done_i && !stall_i) |=> first_cycle_o); // R8

    AST_NO_EXC_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !instr_valid_i |-> !exc_req_o); // R1
endmodule

bind decode_sequencer dseq_chk u_dseq_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .instr_valid_i (instr_valid_i),
    .stall_i       (stall_i),
    .flush_i       (flush_i),
    .mc_done_i     (mc_done_i),
    .first_cycle_o (first_cycle_o),
    .exc_req_o     (exc_req_o)
);

// File: tb/decode_sequencer_test.sv
module decode_sequencer_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid = 1'b0;
    logic [31:0] instr = '0;
    logic        stall = 1'b0;
    logic        flush = 1'b0;
    logic        done = 1'b0;

    logic [4:0] ra, rb, ra32, rb32;
    logic       first, ill_reg, ill_ins, exc;
    logic       first32, ill_reg32, ill_ins32, exc32;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    decode_sequencer #(.NUM_REGS(16)) uut (
        .clk_i(clk), .rst_ni(rst_n), .instr_valid_i(valid), .instr_i(instr),
        .stall_i(stall), .flush_i(flush), .mc_done_i(done),
        .rf_raddr_a_o(ra), .rf_raddr_b_o(rb), .first_cycle_o(first),
        .illegal_reg_o(ill_reg), .illegal_instr_o(ill_ins), .exc_req_o(exc)
    );

    decode_sequencer #(.NUM_REGS(32)) uut32 (
        .clk_i(clk), .rst_ni(rst_n), .instr_valid_i(valid), .instr_i(instr),
        .stall_i(stall), .flush_i(flush), .mc_done_i(done),
        .rf_raddr_a_o(ra32), .rf_raddr_b_o(rb32), .first_cycle_o(first32),
        .illegal_reg_o(ill_reg32), .illegal_instr_o(ill_ins32), .exc_req_o(exc32)
    );

    function automatic logic [31:0] ter(input logic [4:0] rd, rs1, rs2, rs3);
        return {rs3, 2'b11, rs2, rs1, 3'b000, rd, 7'b0110011};
    endfunction

    function automatic logic [31:0] rr(input logic [4:0] rd, rs1, rs2);
        return {5'd0, 2'b00, rs2, rs1, 3'b000, rd, 7'b0110011};
    endfunction

    function automatic logic [31:0] ri(input logic [4:0] rd, rs1, input logic [11:0] imm);
        return {imm, rs1, 3'b000, rd, 7'b0010011};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // Present inputs just after a falling edge, then let them settle.
    task automatic present(input logic v, input logic [31:0] w,
                           input logic s, input logic f, input logic d);
        valid = v; instr = w; stall = s; flush = f; done = d;
        #1;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 first after reset", first, 1);
        chk("R1 no exception after reset", exc, 0);
    endtask

    task automatic t_plain();
        present(1, rr(5'd2, 5'd3, 5'd7), 0, 0, 0);
        chk("R2 port A rs1", ra, 3);
        chk("R2 port B rs2", rb, 7);
        chk("R4 legal regreg no exc", exc, 0);
        tick();
        chk("R3 plain stays first", first, 1);
        present(1, ri(5'd1, 5'd2, 12'hFF0), 0, 0, 0);
        chk("R4 immediate bits not checked", ill_reg, 0);
        present(1, rr(5'd2, 5'd3, 5'd18), 0, 0, 0);
        chk("R4 rs2 out of range", ill_reg, 1);
        chk("R4 exc from rs2", exc, 1);
        tick();
    endtask

    task automatic t_ternary();
        present(1, ter(5'd1, 5'd4, 5'd5, 5'd9), 0, 0, 0);
        chk("R2 ternary first port A", ra, 4);
        chk("R2 ternary first port B", rb, 5);
        tick();
        chk("R3 second cycle flag", first, 0);
        chk("R3 port A rs3", ra, 9);
        chk("R3 port B rs2", rb, 5);
        present(1, 32'hFFFF_FFFF, 0, 0, 0);
        chk("R7 no exc in second cycle", exc, 0);
        chk("R7 no illegal instr in second cycle", ill_ins, 0);
        present(1, ter(5'd1, 5'd4, 5'd5, 5'd9), 0, 0, 1);
        tick();
        chk("R8 done returns to first", first, 1);
        present(0, 32'd0, 0, 0, 0);
        tick();
    endtask

    task automatic t_illegal_then_ternary();
        present(1, rr(5'd20, 5'd1, 5'd2), 0, 0, 0);
        chk("R4 rd out of range", ill_reg, 1);
        chk("R11 exc raised", exc, 1);
        tick();
        present(1, ter(5'd3, 5'd6, 5'd7, 5'd8), 0, 0, 0);
        chk("R11 next sees first flag", first, 1);
        chk("R11 next port A rs1", ra, 6);
        chk("R11 next no exc", exc, 0);
        tick();
        chk("R11 next enters second cycle", first, 0);
        chk("R11 next port A rs3", ra, 8);
        present(1, ter(5'd3, 5'd6, 5'd7, 5'd8), 0, 0, 1);
        tick();
        present(0, 32'd0, 0, 0, 0);
        tick();
    endtask

    task automatic t_illegal_rs3();
        present(1, ter(5'd1, 5'd2, 5'd3, 5'd17), 0, 0, 0);
        chk("R5 rs3 flagged in first cycle", ill_reg, 1);
        chk("R5 port A still rs1", ra, 2);
        tick();
        chk("R5 no entry to second cycle", first, 1);
        present(0, 32'd0, 0, 0, 0);
        tick();
    endtask

    task automatic t_bad_opcode();
        present(1, 32'h0000_007F, 0, 0, 0);
        chk("R6 illegal instr", ill_ins, 1);
        chk("R6 exc", exc, 1);
        chk("R6 not a register fault", ill_reg, 0);
        tick();
        chk("R6 stays first", first, 1);
        present(0, 32'd0, 0, 0, 0);
        tick();
    endtask

    task automatic t_stall();
        present(1, ter(5'd1, 5'd2, 5'd3, 5'd4), 1, 0, 0);
        tick();
        chk("R9 stall blocks entry", first, 1);
        present(1, ter(5'd1, 5'd2, 5'd3, 5'd4), 0, 0, 0);
        tick();
        chk("R9 entry after stall", first, 0);
        present(1, ter(5'd1, 5'd2, 5'd3, 5'd4), 1, 0, 1);
        tick();
        chk("R9 stall holds second cycle", first, 0);
        chk("R9 port A held at rs3", ra, 4);
        present(1, ter(5'd1, 5'd2, 5'd3, 5'd4), 0, 0, 1);
        tick();
        chk("R8 done after stall", first, 1);
        present(0, 32'd0, 0, 0, 0);
        tick();
    endtask

    task automatic t_flush();
        present(1, ter(5'd1, 5'd2, 5'd3, 5'd4), 0, 0, 0);
        tick();
        chk("R10 in second cycle before flush", first, 0);
        present(1, ter(5'd1, 5'd2, 5'd3, 5'd4), 1, 1, 0);
        tick();
        chk("R10 flush beats stall", first, 1);
        present(1, ter(5'd1, 5'd2, 5'd3, 5'd4), 0, 1, 0);
        tick();
        chk("R10 flush blocks entry", first, 1);
        present(0, 32'd0, 0, 0, 0);
        tick();
    endtask

    task automatic t_regs32();
        present(0, 32'd0, 0, 1, 0);
        tick();
        present(1, ter(5'd20, 5'd21, 5'd22, 5'd30), 0, 0, 0);
        chk("R12 no range fault with 32 regs", ill_reg32, 0);
        chk("R12 range fault with 16 regs", ill_reg, 1);
        tick();
        chk("R12 enters second cycle", first32, 0);
        chk("R12 port A rs3", ra32, 30);
        present(0, 32'd0, 0, 1, 0);
        tick();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        #1;
        t_reset();
        t_plain();
        t_ternary();
        t_illegal_then_ternary();
        t_illegal_rs3();
        t_bad_opcode();
        t_stall();
        t_flush();
        t_regs32();
        summary();
        $finish;
    end
endmodule